// File: doc/BRIEF.md
# Masked Fast GPIO Port Register Block

This block is the register side of a 32-bit general-purpose I/O port on a simple synchronous bus with per-byte write enables. It holds three registers. The direction register gives each pin's output enable. The mask register is per bit. The output latch drives the pins. Software can load the output latch through a pin register, or change single bits through a set register and a clear register. A mask bit of 1 hides its pin from all three of those write paths. It also forces the pin's bit to 0 when the pin register is read. Input pins pass through a two-flop synchroniser before any read can see them.

The bus addresses 32-bit words by a 3-bit word index, so the byte offset is the index times four. The byte enables pick which lanes of a word a write touches. This is how the direction register is reached as four byte registers or two half-word registers. The lower half shares offset 0x00 with byte 0. The upper half shares offset 0x02 with byte 2. A small bus state machine runs the transfers and has two states:
- BUS_IDLE: the block accepts requests. A write takes effect at the accepting edge and produces no response cycle. A read moves the machine to BUS_RDATA (transition IDLE->RDATA).
- BUS_RDATA: the block presents the captured read data for exactly one cycle, with `bus_rvalid` high and `bus_ready` low. It then returns unconditionally to BUS_IDLE (transition RDATA->IDLE).

Top module: `mfgpio_port`

## Requirements
- R1: After reset, the direction register, mask register and output latch are all zero, so `pin_oe` and `pin_out` are 0. `bus_ready` is 1 and `bus_rvalid` is 0.
- R2: The direction register is at word index 0 (offset 0x00). Byte-enable bit k writes direction bits 8k+7..8k. `bus_be` = 0011 writes the lower half-word and `bus_be` = 1100 writes the upper half-word. `pin_oe` equals the direction register, where 1 means output.
- R3: The mask register is at word index 4 (offset 0x10). It is written per byte lane like the direction register and reads back its stored value.
- R4: A write to the pin register at word index 5 (offset 0x14) loads output latch bit i from `bus_wdata[i]` only if bit i is in an enabled byte lane and mask bit i is 0.
- R5: A write to the set register at word index 6 (offset 0x18) forces to 1 every latch bit whose write-data bit is 1, whose lane is enabled and whose mask bit is 0. Write-data bits of 0 leave the latch unchanged.
- R6: A write to the clear register at word index 7 (offset 0x1C) forces to 0 every latch bit whose write-data bit is 1, whose lane is enabled and whose mask bit is 0. A read of the clear register returns 0.
- R7: A latch bit whose mask bit is 1 keeps its value through any write to the pin, set or clear register.
- R8: A read of the pin register returns the synchronised input for bits with mask 0 and returns 0 for bits with mask 1. A change on `pin_in` that is present before edge n is visible to a read accepted at edge n+2 or later, and not to a read accepted at edge n+1.
- R9: Reads of the direction and mask registers return their stored values. A read of the set register returns the output latch. Word indices 1, 2 and 3 read as 0, and writes to them change nothing.
- R10: A read accepted in BUS_IDLE gives `bus_rvalid` high for exactly the next cycle, with `bus_ready` low during that cycle. A request presented during BUS_RDATA is ignored, and a write never raises `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Transfer request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word index in the register window |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | High in BUS_IDLE, when a request is accepted |
| bus_rvalid | output | 1 | Read data valid (BUS_RDATA) |
| bus_rdata | output | 32 | Read data |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin output enable (direction) |

## Verification
Some behaviours are checked by assertions on every cycle:
- masked latch bits never change;
- the direction register changes only on an accepted direction write;
- a captured pin read never shows a masked bit;
- the clear register always reads zero;
- every accepted read gets exactly one valid cycle.

Other behaviours only the bench scenarios can show. These include the byte and half-word lane mapping, the combined effect of the set, clear and pin writes on chosen values, and the two-cycle synchroniser latency. They also include the silence of the unmapped words and the dropping of a request made during the response cycle.

// File: rtl/mfgpio_pkg.sv
`timescale 1ns/1ps
package mfgpio_pkg;
    localparam int WORD_W = 3;

    typedef enum logic [WORD_W-1:0] {
        W_DIR  = 3'd0,
        W_RSV1 = 3'd1,
        W_RSV2 = 3'd2,
        W_RSV3 = 3'd3,
        W_MASK = 3'd4,
        W_PIN  = 3'd5,
        W_SET  = 3'd6,
        W_CLR  = 3'd7
    } word_e;

    typedef enum logic [0:0] {
        BUS_IDLE  = 1'b0,
        BUS_RDATA = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic dir;
        logic mask;
        logic pin;
        logic set;
        logic clr;
    } sel_t;
endpackage

// File: rtl/mfgpio_sync.sv
`timescale 1ns/1ps
module mfgpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/mfgpio_decode.sv
`timescale 1ns/1ps
module mfgpio_decode
    import mfgpio_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output sel_t              sel
);
    word_e w;
    assign w = word_e'(word);

    always_comb begin
        sel = '0;
        unique case (w)
            W_DIR:  sel.dir  = 1'b1;
            W_MASK: sel.mask = 1'b1;
            W_PIN:  sel.pin  = 1'b1;
            W_SET:  sel.set  = 1'b1;
            W_CLR:  sel.clr  = 1'b1;
            W_RSV1, W_RSV2, W_RSV3: sel = '0;
        endcase
    end
endmodule

// File: rtl/mfgpio_regs.sv
`timescale 1ns/1ps
module mfgpio_regs
    import mfgpio_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int LANES = WIDTH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  sel_t             sel,
    input  logic [LANES-1:0] be,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] out_o
);
    logic [WIDTH-1:0] dir_q, mask_q, out_q;
    logic [WIDTH-1:0] lane_bits;
    logic [WIDTH-1:0] eff_bits;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign lane_bits[8*k +: 8] = {8{be[k]}};
        end
    endgenerate

    // bits that a pin/set/clear write may touch
    assign eff_bits = lane_bits & ~mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            mask_q <= '0;
            out_q  <= '0;
        end else if (wr_en) begin
            if (sel.dir)  dir_q  <= (dir_q & ~lane_bits) | (wdata & lane_bits);
            if (sel.mask) mask_q <= (mask_q & ~lane_bits) | (wdata & lane_bits);
            if (sel.pin)  out_q  <= (out_q & ~eff_bits) | (wdata & eff_bits);
            if (sel.set)  out_q  <= out_q | (wdata & eff_bits);
            if (sel.clr)  out_q  <= out_q & ~(wdata & eff_bits);
        end
    end

    assign dir_o  = dir_q;
    assign mask_o = mask_q;
    assign out_o  = out_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && mask_q == '0 && out_q == '0));

    // R7
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_q ^ $past(out_q)) & $past(mask_q)) == '0);

    // R2
    dir_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q != $past(dir_q)) |-> ($past(wr_en) && $past(sel.dir)));
endmodule

// File: rtl/mfgpio_port.sv
`timescale 1ns/1ps
module mfgpio_port
    import mfgpio_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LANES = WIDTH / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [LANES-1:0]  bus_be,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    bus_state_e       state_q, state_d;
    sel_t             sel, rd_sel_q;
    logic             accept, wr_en, rd_acc;
    logic [WIDTH-1:0] dir_w, mask_w, out_w, pins_sync;
    logic [WIDTH-1:0] rd_mux, rdata_q;

    mfgpio_decode u_decode (
        .word (bus_word),
        .sel  (sel)
    );

    mfgpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    mfgpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .dir_o  (dir_w),
        .mask_o (mask_w),
        .out_o  (out_w)
    );

    assign accept = bus_req && (state_q == BUS_IDLE);
    assign wr_en  = accept && bus_we;
    assign rd_acc = accept && !bus_we;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (rd_acc) state_d = BUS_RDATA;
            BUS_RDATA: state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // read mux: masked pins read as zero, clear register reads as zero
    always_comb begin
        rd_mux = '0;
        if (sel.dir)  rd_mux = dir_w;
        if (sel.mask) rd_mux = mask_w;
        if (sel.pin)  rd_mux = pins_sync & ~mask_w;
        if (sel.set)  rd_mux = out_w;
    end

    // output process: capture read data on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rd_sel_q <= '0;
        end else if (rd_acc) begin
            rdata_q  <= rd_mux;
            rd_sel_q <= sel;
        end
    end

    assign bus_ready  = (state_q == BUS_IDLE);
    assign bus_rvalid = (state_q == BUS_RDATA);
    assign bus_rdata  = rdata_q;
    assign pin_out    = out_w;
    assign pin_oe     = dir_w;

    // R10
    rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);

    // R10
    read_gets_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && !bus_we) |=> bus_rvalid);

    // R10
    write_no_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && bus_we) |=> !bus_rvalid);

    // R8
    pin_read_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && rd_sel_q.pin) |-> ((bus_rdata & mask_w) == '0));

    // R6
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && rd_sel_q.clr) |-> (bus_rdata == '0));
endmodule

// File: tb/mfgpio_port_bench.sv
`timescale 1ns/1ps
module mfgpio_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    mfgpio_port u_mfgpio_port (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data when the response appears
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R10: unexpected response actual %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // all tasks start just after a falling edge
    task automatic bus_write(input logic [2:0] w, input logic [3:0] be, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_word = w; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        check("R10 write gives no response", {31'b0, bus_rvalid}, 32'd0);
    endtask

    task automatic bus_read(input logic [2:0] w, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_req = 1'b1; bus_we = 1'b0; bus_word = w; bus_be = 4'hF;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R1 pin_oe reset", pin_oe, 32'h0);
        check("R1 pin_out reset", pin_out, 32'h0);
        check("R1 ready reset", {31'b0, bus_ready}, 32'd1);
        check("R1 rvalid reset", {31'b0, bus_rvalid}, 32'd0);
        bus_read(3'd0, 32'h0, "R1 dir reset");
        bus_read(3'd4, 32'h0, "R1 mask reset");

        // R2 direction byte and half-word lanes
        bus_write(3'd0, 4'b0001, 32'hAAAA_AA5A);
        check("R2 byte0 dir", pin_oe, 32'h0000_005A);
        bus_write(3'd0, 4'b0100, 32'h00C3_0000);
        check("R2 byte2 dir", pin_oe, 32'h00C3_005A);
        bus_write(3'd0, 4'b1100, 32'h1234_0000);
        check("R2 upper half dir", pin_oe, 32'h1234_005A);
        bus_write(3'd0, 4'b0011, 32'hFFFF_BEEF);
        check("R2 lower half dir", pin_oe, 32'h1234_BEEF);
        bus_read(3'd0, 32'h1234_BEEF, "R9 dir readback");

        // R4 pin writes, unmasked
        bus_write(3'd5, 4'b1111, 32'h0F0F_0F0F);
        check("R4 pin full write", pin_out, 32'h0F0F_0F0F);
        bus_write(3'd5, 4'b0010, 32'hFFFF_FFFF);
        check("R4 pin lane1 write", pin_out, 32'h0F0F_FF0F);

        // R5 set, R6 clear
        bus_write(3'd6, 4'b1111, 32'hF000_0010);
        check("R5 set", pin_out, 32'hFF0F_FF1F);
        bus_read(3'd6, 32'hFF0F_FF1F, "R9 set reads latch");
        bus_write(3'd7, 4'b1111, 32'h0000_FF00);
        check("R6 clear", pin_out, 32'hFF0F_001F);
        bus_read(3'd7, 32'h0, "R6 clear reads zero");

        // R3 mask
        bus_write(3'd4, 4'b1111, 32'hFFFF_0000);
        bus_read(3'd4, 32'hFFFF_0000, "R3 mask full");
        bus_write(3'd4, 4'b0001, 32'h1111_11F0);
        bus_read(3'd4, 32'hFFFF_00F0, "R3 mask byte0");

        // R7 masked bits hold (unmasked = 0000FF0F)
        bus_write(3'd5, 4'b1111, 32'h0000_0000);
        check("R7 pin write masked", pin_out, 32'hFF0F_0010);
        bus_write(3'd6, 4'b1111, 32'hFFFF_FFFF);
        check("R7 set masked", pin_out, 32'hFF0F_FF1F);
        bus_write(3'd7, 4'b1111, 32'hFFFF_FFFF);
        check("R7 clear masked", pin_out, 32'hFF0F_0010);

        // R8 masked pin read
        pin_in = 32'hA5A5_C3C3;
        repeat (4) @(negedge clk);
        bus_read(3'd5, 32'h0000_C303, "R8 masked pin read");

        // R8 synchroniser latency
        bus_write(3'd4, 4'b1111, 32'h0);
        pin_in = 32'h1234_5678;
        @(negedge clk);
        bus_read(3'd5, 32'hA5A5_C3C3, "R8 one edge old value");
        bus_read(3'd5, 32'h1234_5678, "R8 new value after sync");

        // R9 unmapped words
        bus_write(3'd1, 4'b1111, 32'hFFFF_FFFF);
        bus_write(3'd3, 4'b1111, 32'hFFFF_FFFF);
        bus_read(3'd1, 32'h0, "R9 word1 reads zero");
        bus_read(3'd0, 32'h1234_BEEF, "R9 dir untouched");
        bus_read(3'd4, 32'h0, "R9 mask untouched");
        check("R9 latch untouched", pin_out, 32'hFF0F_0010);

        // R10 request during response cycle is dropped
        exp_q.push_back(32'h0);
        tag_q.push_back("R10 read before dropped write");
        bus_req = 1'b1; bus_we = 1'b0; bus_word = 3'd4;
        @(negedge clk);
        check("R10 ready low in response", {31'b0, bus_ready}, 32'd0);
        bus_we = 1'b1; bus_be = 4'hF; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        bus_read(3'd4, 32'h0, "R10 write in response dropped");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL R10: %0d responses missing, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule